// File: doc/BRIEF.md
# PLL and Bus Clock Frequency Calculator

This block works out three clock frequencies, in hertz, from configuration words that a register file holds elsewhere: the reference input clock, the host PLL output and the peripheral bus clock. It reads a strap word, a PLL parameter word and a clock-select word. It captures them in the first cycle after reset and evaluates the full chain. After that, a one-cycle write strobe on the clock-select word latches a new value and re-derives only the bus frequency.

The block is built in one of two decode variants, chosen by a parameter. Variant A has a 6-bit numerator field, a 4-bit denominator field and an output-divide bit. It falls back to a strap-indexed frequency table when its programmed flag is clear. Variant B has three fields and two chained truncating divisions. Every division, including the bus divide, goes through one shared restoring divider that produces one quotient bit per cycle. A valid flag marks when all three outputs are settled.

Top module: `pfc_freq_calc`

## Requirements
- R1: The reference frequency is 25,000,000 when strap bit 23 is set. Otherwise it is 48,000,000 when strap bit 18 is set, and otherwise 24,000,000.
- R2: If the PLL off flag is set, the PLL frequency is 0. The flag is bit 16 in variant A and bit 19 in variant B.
- R3: Variant A is programmed when bit 18 is set. With bit 18 set and bypass (bit 17) clear, the PLL frequency is ref·(2−od)·⌊(n+2)/(d+1)⌋, taken modulo 2^32. Here n is bits 10:5, od is bit 4 and d is bits 3:0.
- R4: With the bypass flag set and the PLL not off, the PLL frequency equals the reference frequency. In variant A this also needs the programmed flag set. Bypass is bit 17 in variant A and bit 20 in variant B.
- R5: Variant A with bit 18 clear and the PLL not off takes its frequency from a table indexed by strap bits 9:8 (values 0..3). The table is {384,360,336,408} MHz when strap bit 23 is clear and {400,375,350,425} MHz when it is set.
- R6: Variant B without off or bypass gives ref·⌊⌊(m+1)/(n+1)⌋/(p+1)⌋ modulo 2^32. Here p is bits 18:13, m is bits 12:5 and n is bits 4:0.
- R7: The bus frequency is ⌊⌊pll/(k+1)⌋/F⌋, where k is clock-select bits 25:23. F is 2 in variant A and 4 in variant B.
- R8: The strap and PLL words are sampled only in the first cycle after reset. Later changes to them do not alter any output.
- R9: A clock-select strobe re-derives the bus frequency from the newest strobed word and leaves the reference and PLL frequencies unchanged. When strobes arrive during a computation, the last strobed word wins.
- R10: The valid flag is low in reset and in the cycle after any strobe. It rises only when all outputs are final. While it is high and no strobe arrives, it and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_word | input | 32 | Strap configuration word |
| pll_word | input | 32 | PLL parameter word |
| clksel_word | input | 32 | Clock-select word |
| clksel_wr | input | 1 | One-cycle strobe: clock-select word written |
| ref_hz | output | 32 | Reference clock frequency in Hz |
| pll_hz | output | 32 | PLL output frequency in Hz |
| bus_hz | output | 32 | Peripheral bus frequency in Hz |
| freq_valid | output | 1 | All frequencies settled |

## Verification
The bench builds the block twice with default bit positions, once per variant, and drives both from the same words. This lets one sweep compare the two field layouts side by side. It covers every denominator and output-divide value of variant A at extreme numerators, all strap combinations for the table fallback, the off and bypass cases, and a few hundred pseudo-random words. Strobes are also placed mid-computation and back to back, which reaches the last-write-wins and bus-only recompute paths.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic [2:0] {
      ST_INIT, ST_PLL, ST_DIV1, ST_DIV2, ST_BUS, ST_BUSW, ST_IDLE
   } pfc_state_e;

   localparam int unsigned MHZ = 1000000;
   localparam int unsigned REF_24M = 24 * MHZ;
   localparam int unsigned REF_25M = 25 * MHZ;
   localparam int unsigned REF_48M = 48 * MHZ;

   localparam int unsigned VAR_A = 0;
   localparam int unsigned VAR_B = 1;
endpackage

// File: rtl/pfc_ref_select.sv
module pfc_ref_select
   import pfc_pkg::*;
#(
   parameter int unsigned FREQ_W  = 32,
   parameter int unsigned STRAP_W = 32,
   parameter int unsigned B25_BIT = 23,
   parameter int unsigned B48_BIT = 18
) (
   input  logic [STRAP_W-1:0] strap,
   output logic [FREQ_W-1:0]  ref_hz,
   output logic               is_25m
);
   if (B25_BIT >= STRAP_W || B48_BIT >= STRAP_W) begin : g_bad_bits
      $error("strap bit position outside strap word");
   end

   always_comb begin
      is_25m = strap[B25_BIT];
      if (strap[B25_BIT])      ref_hz = FREQ_W'(REF_25M);
      else if (strap[B48_BIT]) ref_hz = FREQ_W'(REF_48M);
      else                     ref_hz = FREQ_W'(REF_24M);
   end
endmodule

// File: rtl/pfc_pll_decode.sv
module pfc_pll_decode
   import pfc_pkg::*;
#(
   parameter int unsigned VARIANT  = 0,
   parameter int unsigned FREQ_W   = 32,
   parameter int unsigned PLL_W    = 32,
   parameter int unsigned STRAP_W  = 32,
   parameter int unsigned OFF_BIT  = 16,
   parameter int unsigned BYP_BIT  = 17,
   parameter int unsigned PROG_BIT = 18,
   parameter int unsigned SEL_LSB  = 8
) (
   input  logic [PLL_W-1:0]   pll_word,
   input  logic [STRAP_W-1:0] strap,
   input  logic               is_25m,
   output logic               pll_off,
   output logic               bypass,
   output logic               use_table,
   output logic [FREQ_W-1:0]  table_hz,
   output logic [FREQ_W-1:0]  num1,
   output logic [FREQ_W-1:0]  den1,
   output logic               two_stage,
   output logic [FREQ_W-1:0]  den2,
   output logic               dbl
);
   if (OFF_BIT >= PLL_W || BYP_BIT >= PLL_W || SEL_LSB + 2 > STRAP_W) begin : g_bad_pos
      $error("PLL flag or strap select position out of range");
   end

   if (VARIANT == VAR_A) begin : g_var_a
      if (PROG_BIT >= PLL_W || PLL_W < 11) begin : g_bad_a
         $error("variant A needs an 11-bit PLL word and a valid programmed bit");
      end
      logic [1:0] sel;
      always_comb begin
         sel       = strap[SEL_LSB +: 2];
         pll_off   = pll_word[OFF_BIT];
         bypass    = pll_word[BYP_BIT];
         use_table = !pll_word[PROG_BIT];
         num1      = FREQ_W'(pll_word[10:5]) + FREQ_W'(2);
         den1      = FREQ_W'(pll_word[3:0]) + FREQ_W'(1);
         dbl       = !pll_word[4];
         two_stage = 1'b0;
         den2      = FREQ_W'(1);
         unique case ({is_25m, sel})
            3'b000:  table_hz = FREQ_W'(384 * MHZ);
            3'b001:  table_hz = FREQ_W'(360 * MHZ);
            3'b010:  table_hz = FREQ_W'(336 * MHZ);
            3'b011:  table_hz = FREQ_W'(408 * MHZ);
            3'b100:  table_hz = FREQ_W'(400 * MHZ);
            3'b101:  table_hz = FREQ_W'(375 * MHZ);
            3'b110:  table_hz = FREQ_W'(350 * MHZ);
            default: table_hz = FREQ_W'(425 * MHZ);
         endcase
      end
   end else if (VARIANT == VAR_B) begin : g_var_b
      if (PLL_W < 19) begin : g_bad_b
         $error("variant B needs a 19-bit PLL word");
      end
      always_comb begin
         pll_off   = pll_word[OFF_BIT];
         bypass    = pll_word[BYP_BIT];
         use_table = 1'b0;
         table_hz  = '0;
         num1      = FREQ_W'(pll_word[12:5]) + FREQ_W'(1);
         den1      = FREQ_W'(pll_word[4:0]) + FREQ_W'(1);
         den2      = FREQ_W'(pll_word[18:13]) + FREQ_W'(1);
         two_stage = 1'b1;
         dbl       = 1'b0;
      end
   end else begin : g_bad_variant
      $error("VARIANT must be 0 or 1");
   end
endmodule

// File: rtl/pfc_divider.sv
module pfc_divider #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quotient,
   output logic         done
);
   localparam int unsigned CNT_W = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("divider width must be at least 2");
   end

   logic [W-1:0]     rem_q, quo_q, den_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, done_q;
   logic [W:0]       shifted, diff;
   logic             fits;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      diff    = shifted - {1'b0, den_q};
      fits    = shifted >= {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         quo_q  <= dividend;
         den_q  <= divisor;
         cnt_q  <= CNT_W'(W);
         run_q  <= 1'b1;
         done_q <= 1'b0;
      end else if (run_q) begin
         rem_q  <= fits ? diff[W-1:0] : shifted[W-1:0];
         quo_q  <= {quo_q[W-2:0], fits};
         cnt_q  <= cnt_q - CNT_W'(1);
         run_q  <= (cnt_q != CNT_W'(1));
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign quotient = quo_q;
   assign done     = done_q;
endmodule

// File: rtl/pfc_freq_calc.sv
module pfc_freq_calc
   import pfc_pkg::*;
#(
   parameter int unsigned VARIANT       = 0,
   parameter int unsigned FREQ_W        = 32,
   parameter int unsigned STRAP_W       = 32,
   parameter int unsigned PLL_W         = 32,
   parameter int unsigned CSEL_W        = 32,
   parameter int unsigned STRAP_25M_BIT = 23,
   parameter int unsigned STRAP_48M_BIT = 18,
   parameter int unsigned STRAP_SEL_LSB = 8,
   parameter int unsigned PLL_OFF_BIT   = (VARIANT == 0) ? 16 : 19,
   parameter int unsigned PLL_BYP_BIT   = (VARIANT == 0) ? 17 : 20,
   parameter int unsigned PLL_PROG_BIT  = 18,
   parameter int unsigned PCLK_LSB      = 23,
   parameter int unsigned PCLK_W        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STRAP_W-1:0] strap_word,
   input  logic [PLL_W-1:0]  pll_word,
   input  logic [CSEL_W-1:0] clksel_word,
   input  logic              clksel_wr,
   output logic [FREQ_W-1:0] ref_hz,
   output logic [FREQ_W-1:0] pll_hz,
   output logic [FREQ_W-1:0] bus_hz,
   output logic              freq_valid
);
   localparam int unsigned BUS_SHIFT = (VARIANT == VAR_A) ? 1 : 2;

   if (FREQ_W < 29) begin : g_bad_freq_w
      $error("FREQ_W too narrow for table frequencies");
   end
   if (PCLK_LSB + PCLK_W > CSEL_W || PCLK_W >= FREQ_W) begin : g_bad_pclk
      $error("bus divide field does not fit");
   end

   pfc_state_e          state_q;
   logic [STRAP_W-1:0]  strap_q;
   logic [PLL_W-1:0]    pll_q;
   logic [CSEL_W-1:0]   clksel_q;
   logic [FREQ_W-1:0]   ref_q, pll_hz_q, bus_hz_q;
   logic                valid_q, pend_q;

   logic [FREQ_W-1:0]   ref_sel;
   logic                is_25m;
   logic                pll_off, bypass, use_table, two_stage, dbl;
   logic [FREQ_W-1:0]   table_hz, num1, den1, den2;

   logic                div_start, div_done;
   logic [FREQ_W-1:0]   div_num, div_den, div_quo;
   logic [FREQ_W-1:0]   prod;

   pfc_ref_select #(
      .FREQ_W (FREQ_W), .STRAP_W (STRAP_W),
      .B25_BIT(STRAP_25M_BIT), .B48_BIT(STRAP_48M_BIT)
   ) ref_sel_i (
      .strap (strap_q), .ref_hz(ref_sel), .is_25m(is_25m)
   );

   pfc_pll_decode #(
      .VARIANT (VARIANT), .FREQ_W(FREQ_W), .PLL_W(PLL_W), .STRAP_W(STRAP_W),
      .OFF_BIT (PLL_OFF_BIT), .BYP_BIT(PLL_BYP_BIT), .PROG_BIT(PLL_PROG_BIT),
      .SEL_LSB (STRAP_SEL_LSB)
   ) dec_i (
      .pll_word (pll_q), .strap(strap_q), .is_25m(is_25m),
      .pll_off  (pll_off), .bypass(bypass), .use_table(use_table),
      .table_hz (table_hz), .num1(num1), .den1(den1),
      .two_stage(two_stage), .den2(den2), .dbl(dbl)
   );

   pfc_divider #(.W(FREQ_W)) div_i (
      .clk     (clk), .rst_n(rst_n), .start(div_start),
      .dividend(div_num), .divisor(div_den),
      .quotient(div_quo), .done(div_done)
   );

   // Operand steering for the one shared divider.
   always_comb begin
      div_start = 1'b0;
      div_num   = num1;
      div_den   = den1;
      unique case (state_q)
         ST_PLL:  div_start = !pll_off && !use_table && !bypass;
         ST_DIV1: begin
            div_start = div_done && two_stage;
            div_num   = div_quo;
            div_den   = den2;
         end
         ST_BUS: begin
            div_start = 1'b1;
            div_num   = pll_hz_q;
            div_den   = FREQ_W'(clksel_q[PCLK_LSB +: PCLK_W]) + FREQ_W'(1);
         end
         default: ;
      endcase
   end

   assign prod = ref_q * div_quo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_INIT;
         strap_q  <= '0;
         pll_q    <= '0;
         clksel_q <= '0;
         ref_q    <= '0;
         pll_hz_q <= '0;
         bus_hz_q <= '0;
         valid_q  <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (clksel_wr) begin
            clksel_q <= clksel_word;
            pend_q   <= 1'b1;
            valid_q  <= 1'b0;
         end
         unique case (state_q)
            ST_INIT: begin
               strap_q  <= strap_word;
               pll_q    <= pll_word;
               clksel_q <= clksel_word;
               state_q  <= ST_PLL;
            end
            ST_PLL: begin
               ref_q <= ref_sel;
               if (pll_off) begin
                  pll_hz_q <= '0;
                  state_q  <= ST_BUS;
               end else if (use_table) begin
                  pll_hz_q <= table_hz;
                  state_q  <= ST_BUS;
               end else if (bypass) begin
                  pll_hz_q <= ref_sel;
                  state_q  <= ST_BUS;
               end else begin
                  state_q  <= ST_DIV1;
               end
            end
            ST_DIV1: if (div_done) begin
               if (two_stage) begin
                  state_q <= ST_DIV2;
               end else begin
                  pll_hz_q <= dbl ? (prod << 1) : prod;
                  state_q  <= ST_BUS;
               end
            end
            ST_DIV2: if (div_done) begin
               pll_hz_q <= prod;
               state_q  <= ST_BUS;
            end
            ST_BUS: begin
               if (!clksel_wr) pend_q <= 1'b0;
               state_q <= ST_BUSW;
            end
            ST_BUSW: if (div_done) begin
               bus_hz_q <= div_quo >> BUS_SHIFT;
               if (pend_q || clksel_wr) begin
                  state_q <= ST_BUS;
               end else begin
                  state_q <= ST_IDLE;
                  valid_q <= 1'b1;
               end
            end
            ST_IDLE: if (pend_q) state_q <= ST_BUS;
            default: state_q <= ST_INIT;
         endcase
      end
   end

   assign ref_hz     = ref_q;
   assign pll_hz     = pll_hz_q;
   assign bus_hz     = bus_hz_q;
   assign freq_valid = valid_q;
endmodule

// File: rtl/pfc_freq_calc_chk.sv
module pfc_freq_calc_chk
   import pfc_pkg::*;
#(
   parameter int unsigned FREQ_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clksel_wr,
   input logic [FREQ_W-1:0] ref_hz,
   input logic [FREQ_W-1:0] pll_hz,
   input logic [FREQ_W-1:0] bus_hz,
   input logic              freq_valid
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen_q <= 1'b0;
      else if (freq_valid) seen_q <= 1'b1;
   end

   // R10
   strobe_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clksel_wr |=> !freq_valid);

   // R10
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid && !clksel_wr |=> freq_valid && $stable(ref_hz)
                                   && $stable(pll_hz) && $stable(bus_hz));

   // R8
   pll_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> $stable(pll_hz) && $stable(ref_hz));

   // R1
   ref_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid |-> (ref_hz == FREQ_W'(REF_24M)) || (ref_hz == FREQ_W'(REF_25M))
                     || (ref_hz == FREQ_W'(REF_48M)));

   // R7
   bus_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_valid |-> bus_hz <= pll_hz);
endmodule

bind pfc_freq_calc pfc_freq_calc_chk #(.FREQ_W(FREQ_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .clksel_wr (clksel_wr),
   .ref_hz    (ref_hz),
   .pll_hz    (pll_hz),
   .bus_hz    (bus_hz),
   .freq_valid(freq_valid)
);

// File: tb/pfc_freq_calc_tb_top.sv
module pfc_freq_calc_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] strap_word = '0, pll_word = '0, clksel_word = '0;
   logic        clksel_wr = 1'b0;
   logic [31:0] ref_a, pll_a, bus_a, ref_b, pll_b, bus_b;
   logic        val_a, val_b;

   int total = 0, fails = 0, cyc = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pfc_freq_calc #(.VARIANT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_word(strap_word), .pll_word(pll_word),
      .clksel_word(clksel_word), .clksel_wr(clksel_wr),
      .ref_hz(ref_a), .pll_hz(pll_a), .bus_hz(bus_a), .freq_valid(val_a));

   pfc_freq_calc #(.VARIANT(1)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .strap_word(strap_word), .pll_word(pll_word),
      .clksel_word(clksel_word), .clksel_wr(clksel_wr),
      .ref_hz(ref_b), .pll_hz(pll_b), .bus_hz(bus_b), .freq_valid(val_b));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WATCHDOG) begin
         total = total + 1;
         fails = fails + 1;
         $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   function automatic logic [31:0] m_ref(input logic [31:0] s);
      if (s[23])      return 32'd25000000;
      else if (s[18]) return 32'd48000000;
      else            return 32'd24000000;
   endfunction

   function automatic logic [31:0] m_pll_a(input logic [31:0] s, input logic [31:0] w);
      logic [31:0] mult, mhz;
      if (w[16]) return 32'd0;
      if (!w[18]) begin
         case (s[9:8])
            2'd0:    mhz = s[23] ? 32'd400 : 32'd384;
            2'd1:    mhz = s[23] ? 32'd375 : 32'd360;
            2'd2:    mhz = s[23] ? 32'd350 : 32'd336;
            default: mhz = s[23] ? 32'd425 : 32'd408;
         endcase
         return mhz * 32'd1000000;
      end
      if (w[17]) return m_ref(s);
      mult = (32'd2 - 32'(w[4])) * ((32'(w[10:5]) + 32'd2) / (32'(w[3:0]) + 32'd1));
      return m_ref(s) * mult;
   endfunction

   function automatic logic [31:0] m_pll_b(input logic [31:0] s, input logic [31:0] w);
      logic [31:0] mult;
      if (w[19]) return 32'd0;
      if (w[20]) return m_ref(s);
      mult = ((32'(w[12:5]) + 32'd1) / (32'(w[4:0]) + 32'd1)) / (32'(w[18:13]) + 32'd1);
      return m_ref(s) * mult;
   endfunction

   function automatic logic [31:0] m_bus(input logic [31:0] p, input logic [31:0] c,
                                        input logic [31:0] fixdiv);
      return (p / (32'(c[25:23]) + 32'd1)) / fixdiv;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_valid();
      bit ok = 0;
      for (int k = 0; k < 1000; k++) begin
         if (val_a && val_b) begin ok = 1; break; end
         @(negedge clk);
      end
      if (!ok) chk("R10 valid timeout", 32'(val_a & val_b), 32'd1);
   endtask

   task automatic restart(input logic [31:0] s, input logic [31:0] w, input logic [31:0] c);
      @(negedge clk);
      rst_n = 1'b0;
      strap_word = s; pll_word = w; clksel_word = c;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_all(input string pa_tag, input string pb_tag,
                            input logic [31:0] s, input logic [31:0] w, input logic [31:0] c);
      chk("R1 ref A", ref_a, m_ref(s));
      chk("R1 ref B", ref_b, m_ref(s));
      chk(pa_tag, pll_a, m_pll_a(s, w));
      chk(pb_tag, pll_b, m_pll_b(s, w));
      chk("R7 bus A", bus_a, m_bus(m_pll_a(s, w), c, 32'd2));
      chk("R7 bus B", bus_b, m_bus(m_pll_b(s, w), c, 32'd4));
   endtask

   task automatic run_point(input string pa_tag, input string pb_tag,
                            input logic [31:0] s, input logic [31:0] w, input logic [31:0] c);
      restart(s, w, c);
      wait_valid();
      check_all(pa_tag, pb_tag, s, w, c);
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] x);
      return x * 32'd1664525 + 32'd1013904223;
   endfunction

   initial begin
      logic [31:0] s0, w0, c0, keep_pa, keep_pb, keep_r;

      // Reset state (R10)
      repeat (3) @(negedge clk);
      chk("R10 reset valid A", 32'(val_a), 32'd0);
      chk("R10 reset valid B", 32'(val_b), 32'd0);
      chk("R10 reset pll A", pll_a, 32'd0);
      chk("R10 reset bus B", bus_b, 32'd0);

      // R5 table sweep over strap 25M/48M bits and select
      for (int i = 0; i < 16; i++) begin
         s0 = (32'(i[3]) << 23) | (32'(i[2]) << 18) | (32'(i[1:0]) << 8);
         run_point("R5 table A", "R6 unity B", s0, 32'h0, 32'(i) << 23);
      end

      // R2 off flags
      run_point("R2 off A", "R2 off B", 32'h0080_0000, 32'h0009_0000 | 32'h0004_0000, 32'h0);
      run_point("R2 off A", "R2 off B", 32'h0004_0000, 32'h0009_07FF | 32'h0004_0000, 32'h0380_0000);

      // R4 bypass
      run_point("R4 bypass A", "R4 bypass B", 32'h0000_0000, 32'h0016_0000 | 32'h0001_0000 ^ 32'h0001_0000, 32'h0100_0000);
      run_point("R4 bypass A", "R4 bypass B", 32'h0004_0000, 32'h0016_03FF, 32'h0280_0000);

      // R3 formula sweep: extreme numerators, all od and d
      for (int n = 0; n < 4; n++) begin
         for (int od = 0; od < 2; od++) begin
            for (int d = 0; d < 16; d++) begin
               logic [5:0] nv;
               nv = (n == 0) ? 6'd0 : (n == 1) ? 6'd1 : (n == 2) ? 6'd30 : 6'd63;
               w0 = 32'h0004_0000 | (32'(nv) << 5) | (32'(od) << 4) | 32'(d);
               s0 = (d[0]) ? 32'h0080_0000 : ((d[1]) ? 32'h0004_0000 : 32'h0);
               run_point("R3 formula A", "R6 formula B", s0, w0, 32'(d[2:0]) << 23);
            end
         end
      end

      // Pseudo-random words (R3, R6)
      for (int i = 0; i < 300; i++) begin
         seed = next_rand(seed); w0 = seed;
         seed = next_rand(seed); s0 = seed;
         seed = next_rand(seed); c0 = seed;
         run_point("R3 random A", "R6 random B", s0, w0, c0);
      end

      // R8: inputs changed after sampling have no effect
      s0 = 32'h0000_0100; w0 = 32'h0004_1D45; c0 = 32'h0100_0000;
      run_point("R3 base A", "R6 base B", s0, w0, c0);
      keep_pa = pll_a; keep_pb = pll_b; keep_r = ref_a;
      strap_word = 32'h0080_0300; pll_word = 32'h0011_0000;
      repeat (60) @(negedge clk);
      chk("R8 pll A held", pll_a, keep_pa);
      chk("R8 pll B held", pll_b, keep_pb);
      chk("R8 ref held", ref_a, keep_r);
      chk("R8 bus A held", bus_a, m_bus(keep_pa, c0, 32'd2));

      // R9/R10: single strobe, bus only
      clksel_word = 32'h0300_0000; clksel_wr = 1'b1;
      @(negedge clk);
      clksel_wr = 1'b0;
      chk("R10 valid drop A", 32'(val_a), 32'd0);
      chk("R10 valid drop B", 32'(val_b), 32'd0);
      wait_valid();
      chk("R9 pll A kept", pll_a, keep_pa);
      chk("R9 pll B kept", pll_b, keep_pb);
      chk("R9 bus A new", bus_a, m_bus(keep_pa, 32'h0300_0000, 32'd2));
      chk("R9 bus B new", bus_b, m_bus(keep_pb, 32'h0300_0000, 32'd4));

      // R9: back-to-back strobes, last wins
      clksel_word = 32'h0080_0000; clksel_wr = 1'b1;
      @(negedge clk);
      chk("R10 valid drop b2b", 32'(val_a), 32'd0);
      clksel_word = 32'h0200_0000;
      @(negedge clk);
      clksel_wr = 1'b0;
      repeat (20) @(negedge clk);
      clksel_word = 32'h0180_0000; clksel_wr = 1'b1;
      @(negedge clk);
      clksel_wr = 1'b0; clksel_word = 32'h0;
      wait_valid();
      chk("R9 last wins A", bus_a, m_bus(keep_pa, 32'h0180_0000, 32'd2));
      chk("R9 last wins B", bus_b, m_bus(keep_pb, 32'h0180_0000, 32'd4));
      chk("R9 pll unchanged", pll_a, keep_pa);

      // R9: strobe during PLL computation
      s0 = 32'h0004_0000; w0 = 32'h0004_07E0; c0 = 32'h0000_0000;
      restart(s0, w0, c0);
      repeat (3) @(negedge clk);
      clksel_word = 32'h0280_0000; clksel_wr = 1'b1;
      @(negedge clk);
      clksel_wr = 1'b0;
      wait_valid();
      check_all("R3 mid A", "R6 mid B", s0, w0, 32'h0280_0000);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule